// File: doc/BRIEF.md
# Double-Precision NaN Screen for a Multiplier Result Path

This block sits after the arithmetic core of a double-precision multiplier and decides whether the product that core computed may leave the unit. Each operand is 64 bits wide. Bit 63 is the sign, bits 62:52 are an 11-bit biased exponent, bit 51 is an explicit integer bit and bits 50:0 are the fraction. The block sorts both operands into one of five classes and reports the class of each.

The block replaces the pending product with a single fixed quiet NaN in three cases: either operand is a NaN, the pair is zero times infinity, or the pending product is itself a NaN. It raises an invalid-operation flag when the operation has no defined value (zero times infinity) and when a signaling NaN arrives as an operand. In every other case the pending product passes through bit for bit.

Results, class codes and the flag are captured on the clock edge that samples the input strobe. They appear one cycle later with an output strobe. The block does not round and does not compute the product.

Top module: `dpnan_unit`

## Requirements
- R1: `cls_a` and `cls_b` report each operand's class with the codes 0 = finite, 1 = zero, 2 = infinity, 3 = quiet NaN, 4 = signaling NaN. Codes 5 to 7 never appear.
- R2: An operand is a NaN when bits 62:52 are all ones, bit 51 is 1 and bits 50:0 are not all zero. It is quiet when bit 50 is 1 and signaling when bit 50 is 0. The sign bit 63 never changes the class.
- R3: An operand with bits 62:0 all zero is a zero of either sign. Exponent all ones, bit 51 set and fraction zero is an infinity of either sign. Every other encoding, including all-ones exponent with bit 51 clear, is finite.
- R4: When neither operand is a NaN and one is zero while the other is infinity, in either order, the result is the canonical quiet NaN 64'h7FFF_FFFF_FFFF_FFFF.
- R5: When either operand is a NaN of either kind, the result is the canonical quiet NaN, whatever the pending product holds.
- R6: `inv_flag` is 1 exactly when an operand is a signaling NaN or the pair is zero times infinity. Quiet NaN operands alone leave it 0.
- R7: A pending product that is a NaN of either kind is replaced by the canonical quiet NaN, and this alone does not raise `inv_flag`.
- R8: In all other cases `out_res` equals the pending product unchanged and `inv_flag` is 0.
- R9: Outputs are registered. A strobe on `in_vld` at one rising edge gives `out_vld` = 1 with the matching outputs after that edge. Without a strobe, `out_vld` is 0 and the other outputs keep their values.
- R10: During reset, `out_vld`, `out_res`, `cls_a`, `cls_b` and `inv_flag` are all 0.
- R11: `out_res` never holds a signaling NaN while `out_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operands and pending product are valid this cycle |
| op_a | input | 64 | First multiplier operand |
| op_b | input | 64 | Second multiplier operand |
| arith_res | input | 64 | Product computed by the arithmetic core |
| out_vld | output | 1 | Registered outputs are new this cycle |
| out_res | output | 64 | Final result |
| cls_a | output | 3 | Class code of `op_a` |
| cls_b | output | 3 | Class code of `op_b` |
| inv_flag | output | 1 | Invalid-operation flag |

## Verification
The bench targets the points where the classes touch.
- A signaling NaN whose only set fraction bit is bit 0: a design that tests only bit 50 would call it infinity.
- An all-ones exponent with bit 51 clear: a design that ignores the integer bit would call it infinity or a NaN.
- Negative-signed NaNs: a sign-sensitive decoder would misclassify them or copy the sign into the result.
- A quiet NaN times zero: a design that forgets NaN priority over the invalid pair would raise the flag.
- A signaling NaN arriving as the pending product: a design without that guard would emit the signaling NaN.

The bench also changes the inputs while `in_vld` is low, which catches a register that loads on every cycle.

// File: rtl/dpnan_pkg.sv
package dpnan_pkg;

  typedef enum logic [2:0] {
    CLS_FIN  = 3'd0,
    CLS_ZERO = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fpcls_e;

  function automatic logic cls_is_nan(fpcls_e c);
    return (c == CLS_QNAN) || (c == CLS_SNAN);
  endfunction

endpackage

// File: rtl/dpnan_classify.sv
module dpnan_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 51
) (
  input  logic [EXP_W+FRAC_W+1:0] val,
  output dpnan_pkg::fpcls_e        cls
);
  import dpnan_pkg::*;

  localparam int INT_POS = FRAC_W;
  localparam int EXP_LSB = FRAC_W + 1;
  localparam int SGN_POS = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  exp_f;
  logic              int_b;
  logic [FRAC_W-1:0] frac_f;
  logic              unused_sign;

  assign exp_f       = val[EXP_LSB +: EXP_W];
  assign int_b       = val[INT_POS];
  assign frac_f      = val[FRAC_W-1:0];
  assign unused_sign = val[SGN_POS];

  // Sign plays no part: only exponent, integer bit and fraction decide.
  function automatic fpcls_e sort_fields(logic [EXP_W-1:0] e, logic ib,
                                         logic [FRAC_W-1:0] f);
    logic e_max;
    logic e_min;
    logic f_nz;
    e_max = &e;
    e_min = ~|e;
    f_nz  = |f;
    if (e_max && ib && f_nz) return f[FRAC_W-1] ? CLS_QNAN : CLS_SNAN;
    if (e_max && ib)         return CLS_INF;
    if (e_min && !ib && !f_nz) return CLS_ZERO;
    return CLS_FIN;
  endfunction

  assign cls = sort_fields(exp_f, int_b, frac_f);

endmodule

// File: rtl/dpnan_policy.sv
module dpnan_policy #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 51
) (
  input  dpnan_pkg::fpcls_e        cls_a,
  input  dpnan_pkg::fpcls_e        cls_b,
  input  dpnan_pkg::fpcls_e        cls_r,
  input  logic [EXP_W+FRAC_W+1:0]  res_in,
  output logic [EXP_W+FRAC_W+1:0]  res_out,
  output logic                     inv_op,
  output logic                     nan_op,
  output logic                     snan_in,
  output logic                     bad_pair,
  output logic                     force_nan
);
  import dpnan_pkg::*;

  localparam int DW = EXP_W + FRAC_W + 2;

  function automatic logic [DW-1:0] canon_qnan();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {FRAC_W{1'b1}}};
  endfunction

  function automatic logic zero_inf(fpcls_e x, fpcls_e y);
    return ((x == CLS_ZERO) && (y == CLS_INF)) ||
           ((x == CLS_INF)  && (y == CLS_ZERO));
  endfunction

  assign nan_op    = cls_is_nan(cls_a) || cls_is_nan(cls_b);
  assign snan_in   = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
  assign bad_pair  = !nan_op && zero_inf(cls_a, cls_b);
  assign force_nan = nan_op || bad_pair || cls_is_nan(cls_r);
  assign inv_op    = snan_in || bad_pair;
  assign res_out   = force_nan ? canon_qnan() : res_in;

endmodule

// File: rtl/dpnan_outreg.sv
module dpnan_outreg #(
  parameter int DW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DW-1:0]     d_res,
  input  dpnan_pkg::fpcls_e d_ca,
  input  dpnan_pkg::fpcls_e d_cb,
  input  logic              d_inv,
  output logic              q_vld,
  output logic [DW-1:0]     q_res,
  output logic [2:0]        q_ca,
  output logic [2:0]        q_cb,
  output logic              q_inv
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
      q_res <= '0;
      q_ca  <= '0;
      q_cb  <= '0;
      q_inv <= 1'b0;
    end else begin
      q_vld <= load;
      if (load) begin
        q_res <= d_res;
        q_ca  <= d_ca;
        q_cb  <= d_cb;
        q_inv <= d_inv;
      end
    end
  end

endmodule

// File: rtl/dpnan_unit.sv
module dpnan_unit #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 51
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [EXP_W+FRAC_W+1:0] op_a,
  input  logic [EXP_W+FRAC_W+1:0] op_b,
  input  logic [EXP_W+FRAC_W+1:0] arith_res,
  output logic                    out_vld,
  output logic [EXP_W+FRAC_W+1:0] out_res,
  output logic [2:0]              cls_a,
  output logic [2:0]              cls_b,
  output logic                    inv_flag
);
  import dpnan_pkg::*;

  localparam int DW    = EXP_W + FRAC_W + 2;
  localparam int N_SRC = 3;

  logic [DW-1:0] src_v [N_SRC];
  fpcls_e        cls_v [N_SRC];

  assign src_v[0] = op_a;
  assign src_v[1] = op_b;
  assign src_v[2] = arith_res;

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_cls
    dpnan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val (src_v[gi]),
      .cls (cls_v[gi])
    );
  end

  logic [DW-1:0] res_next;
  logic          inv_next;
  logic          nan_op;
  logic          snan_in;
  logic          bad_pair;
  logic          force_nan;

  dpnan_policy #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pol (
    .cls_a     (cls_v[0]),
    .cls_b     (cls_v[1]),
    .cls_r     (cls_v[2]),
    .res_in    (arith_res),
    .res_out   (res_next),
    .inv_op    (inv_next),
    .nan_op    (nan_op),
    .snan_in   (snan_in),
    .bad_pair  (bad_pair),
    .force_nan (force_nan)
  );

  dpnan_outreg #(.DW(DW)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_vld),
    .d_res (res_next),
    .d_ca  (cls_v[0]),
    .d_cb  (cls_v[1]),
    .d_inv (inv_next),
    .q_vld (out_vld),
    .q_res (out_res),
    .q_ca  (cls_a),
    .q_cb  (cls_b),
    .q_inv (inv_flag)
  );

endmodule

// File: rtl/dpnan_chk.sv
module dpnan_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 51
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_vld,
  input logic [EXP_W+FRAC_W+1:0] arith_res,
  input logic                    out_vld,
  input logic [EXP_W+FRAC_W+1:0] out_res,
  input logic [2:0]              cls_a,
  input logic [2:0]              cls_b,
  input logic                    inv_flag,
  input logic                    nan_op,
  input logic                    snan_in,
  input logic                    bad_pair,
  input logic                    force_nan
);
  localparam int DW = EXP_W + FRAC_W + 2;
  localparam logic [DW-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {FRAC_W{1'b1}}};

  logic out_is_nan;
  logic out_is_snan;
  assign out_is_nan  = (&out_res[DW-2 -: EXP_W]) && out_res[FRAC_W] &&
                       (|out_res[FRAC_W-1:0]);
  assign out_is_snan = out_is_nan && !out_res[FRAC_W-1];

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);  // R9
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);  // R9
  AST_HOLD_RES: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_res));  // R9
  AST_NO_SNAN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> !out_is_snan);  // R11
  AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_is_nan && in_vld) |-> 1'b1 ##0 (out_res == CANON) || !force_nan);  // R5
  AST_NAN_OP_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && nan_op) |=> (out_res == CANON));  // R5
  AST_PAIR_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && bad_pair) |=> (out_res == CANON && inv_flag));  // R4
  AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && snan_in) |=> inv_flag);  // R6
  AST_QUIET_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !snan_in && !bad_pair) |=> !inv_flag);  // R6
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !force_nan) |=> (out_res == $past(arith_res)));  // R8
  AST_CLS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (cls_a <= 3'd4 && cls_b <= 3'd4));  // R1

endmodule

bind dpnan_unit dpnan_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_vld    (in_vld),
  .arith_res (arith_res),
  .out_vld   (out_vld),
  .out_res   (out_res),
  .cls_a     (cls_a),
  .cls_b     (cls_b),
  .inv_flag  (inv_flag),
  .nan_op    (nan_op),
  .snan_in   (snan_in),
  .bad_pair  (bad_pair),
  .force_nan (force_nan)
);

// File: tb/sim_dpnan_unit.sv
module sim_dpnan_unit;
  localparam int CLK_PER = 10;
  localparam logic [63:0] QCANON = 64'h7FFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [63:0] arith_res = '0;
  logic        out_vld;
  logic [63:0] out_res;
  logic [2:0]  cls_a;
  logic [2:0]  cls_b;
  logic        inv_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  dpnan_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .arith_res(arith_res), .out_vld(out_vld), .out_res(out_res),
    .cls_a(cls_a), .cls_b(cls_b), .inv_flag(inv_flag)
  );

  // Reference model written from the requirements.
  function automatic logic [2:0] ref_cls(logic [63:0] x);
    logic [63:0] mag;
    logic [10:0] ex;
    logic [50:0] fr;
    mag = x & ~(64'd1 << 63);
    ex  = 11'((mag >> 52) & 64'h7FF);
    fr  = 51'(mag);
    if (ex == 11'h7FF && mag[51] && fr != 0) return fr[50] ? 3'd3 : 3'd4;
    if (ex == 11'h7FF && mag[51]) return 3'd2;
    if (mag == 0) return 3'd1;
    return 3'd0;
  endfunction

  function automatic logic [63:0] mk_op(int kind);
    logic [63:0] r;
    logic        s;
    logic [10:0] e;
    r = {$urandom(), $urandom()};
    s = r[63];
    e = 11'(1 + (r[62:52] % 11'd2046));
    case (kind)
      0: return {s, e, 1'b1, r[50:0]};
      1: return {s, 63'd0};
      2: return {s, 11'h7FF, 1'b1, 51'd0};
      3: return {s, 11'h7FF, 1'b1, 1'b1, r[49:0]};
      4: return {s, 11'h7FF, 1'b1, 1'b0, r[49:0] | 50'd1};
      default: return {s, 11'h7FF, 1'b0, r[50:0]};
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(logic [63:0] a, logic [63:0] b, logic [63:0] r);
    logic [2:0] ca, cb, cr;
    logic nan_any, pair, snan, exp_inv;
    logic [63:0] exp_res;
    string rtag;
    op_a = a; op_b = b; arith_res = r; in_vld = 1'b1;
    ca = ref_cls(a); cb = ref_cls(b); cr = ref_cls(r);
    nan_any = (ca >= 3) || (cb >= 3);
    snan = (ca == 4) || (cb == 4);
    pair = !nan_any && ((ca == 1 && cb == 2) || (ca == 2 && cb == 1));
    exp_inv = snan || pair;
    if (nan_any) begin exp_res = QCANON; rtag = "R5"; end
    else if (pair) begin exp_res = QCANON; rtag = "R4"; end
    else if (cr >= 3) begin exp_res = QCANON; rtag = "R7"; end
    else begin exp_res = r; rtag = "R8"; end
    @(negedge clk);
    in_vld = 1'b0;
    check("R9 out_vld", 64'(out_vld), 64'd1);
    check("R1/R2/R3 cls_a", 64'(cls_a), 64'(ca));
    check("R1/R2/R3 cls_b", 64'(cls_b), 64'(cb));
    check("R6 inv_flag", 64'(inv_flag), 64'(exp_inv));
    check({rtag, " out_res"}, out_res, exp_res);
    check("R11 no signaling out", 64'(ref_cls(out_res) == 3'd4), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 out_vld", 64'(out_vld), 64'd0);
    check("R10 out_res", out_res, 64'd0);
    check("R10 cls", 64'({cls_a, cls_b}), 64'd0);
    check("R10 inv_flag", 64'(inv_flag), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: zero times infinity, both orders and signs
    run_one(64'd0, 64'h7FF8_0000_0000_0000, 64'h1234);
    run_one(64'hFFF8_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0);
    // R6: quiet NaN times zero gives no flag; R2 negative quiet NaN
    run_one(64'hFFFC_0000_0000_0001, 64'd0, 64'h3FF8_0000_0000_0000);
    // R2: signaling NaN with only the lowest fraction bit set
    run_one(64'h7FF8_0000_0000_0001, 64'h3FF8_0000_0000_0000, 64'h5);
    // R3: all-ones exponent with integer bit clear is finite
    run_one(64'h7FF0_0000_0000_0000, 64'd0, 64'h4000_0000_0000_0000);
    // R7: pending product is a signaling NaN, then a quiet one
    run_one(64'h3FF8_0000_0000_0000, 64'h4008_0000_0000_0000, 64'hFFF8_0000_0000_00FF);
    run_one(64'h3FF8_0000_0000_0000, 64'h4008_0000_0000_0000, 64'h7FFC_0000_0000_0000);
    // R8: plain pass-through
    run_one(64'h3FF8_0000_0000_0000, 64'h4008_0000_0000_0000, 64'h4018_0000_0000_0000);

    // R9: no strobe, inputs move, outputs hold
    held = out_res;
    op_a = 64'd0; op_b = 64'h7FF8_0000_0000_0000; arith_res = 64'hDEAD;
    @(negedge clk);
    check("R9 idle out_vld", 64'(out_vld), 64'd0);
    check("R9 idle out_res held", out_res, held);
    check("R9 idle flag held", 64'(inv_flag), 64'd0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int ka, kb, kr;
      ka = $urandom_range(0, 5);
      kb = $urandom_range(0, 5);
      kr = ($urandom_range(0, 3) == 0) ? $urandom_range(3, 4) : 0;
      run_one(mk_op(ka), mk_op(kb), mk_op(kr));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule